// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit with Conditional Move

This block is the integer arithmetic slice of a simple execution stage. On each valid strobe it adds or subtracts two operands of a parameterised width, or passes the second operand through as a move. It then decides whether the destination register may be written. Add, subtract and compare update a registered set of four condition flags: negative, zero, carry/borrow and signed overflow. A move does not touch the flags.

Compare performs the same subtraction as subtract and updates the flags, but it never asserts the write enable. A move is gated by a condition code that is evaluated against the flags held in the register. The usual pattern is therefore a compare in one cycle and a conditional move in a later one. The hardware makes no distinction between signed and unsigned operands. Carry and overflow are both produced on every arithmetic operation, and the consumer picks the one that matters.

Top module: `flagalu_top`

## Requirements
- R1: With op code 0 (add), `result` is `opa + opb` modulo 2^WIDTH. `wr_en` is high, and the stored C flag is set exactly when a carry leaves the most significant bit (8-bit 220 + 50 gives 14 with C=1).
- R2: With op code 1 (subtract), `result` is `opa - opb` modulo 2^WIDTH. `wr_en` is high, and C is set exactly when a borrow is needed out of the most significant bit, meaning `opa < opb` unsigned.
- R3: After add, subtract or compare, the Z flag is 1 exactly when the computed result is all zeros.
- R4: After add, subtract or compare, the N flag equals the most significant bit of the computed result.
- R5: For add, V is set only when both operands have the same sign and the result sign differs from theirs (8-bit: 100+50 gives V=1, -128 + -128 gives V=1, 127+127 gives V=1). Operands of opposite sign never set V.
- R6: For subtract and compare `opa - opb`, V is set exactly when the operands differ in sign and the result sign differs from `opa`.
- R7: With op code 2 (compare), the flags update as for subtract while `wr_en` stays low.
- R8: With op code 3 (move), `result` equals `opb` and `wr_en` is high only when the condition code holds against the stored flags. The condition codes are: 0 equal (Z=1), 1 not-equal (Z=0), 2 signed greater-or-equal (N==V), 3 signed less-than (N!=V), and 4 always. Codes 5 to 7 never hold.
- R9: The flags keep their value across move operations and across cycles with `in_valid` low. `wr_en` is low whenever `in_valid` is low.
- R10: `status` is 32 bits wide, with N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. All other bits read 0.
- R11: A synchronous active-high reset clears all four flags. The flags update on the clock edge that samples a valid add, subtract or compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Operation: 0 add, 1 subtract, 2 compare, 3 move |
| cond | input | 3 | Condition code for move |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand (move source) |
| result | output | WIDTH | Arithmetic result or moved value |
| wr_en | output | 1 | Destination write enable |
| status | output | 32 | Registered flag word |

## Verification
The assertions check the following on every cycle:
- compare never writes;
- an idle strobe never writes;
- moves and idle cycles leave the flag word unchanged;
- the reserved status bits stay zero;
- Z tracks the previous result;
- mixed-sign additions never raise V;
- reset clears the flags.

Only the bench scenarios can show the exact arithmetic values, the carry-versus-borrow polarity, and the signed overflow corner sums. The same holds for each condition code being tested against flags left behind by an earlier compare.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

    localparam int STATUS_W = 32;
    localparam int N_POS    = 31;
    localparam int Z_POS    = 30;
    localparam int C_POS    = 29;
    localparam int V_POS    = 28;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_CMP = 2'd2,
        OP_MOV = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_GE = 3'd2,
        CC_LT = 3'd3,
        CC_AL = 3'd4
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Evaluate a condition code against a flag set; unused codes never pass.
    function automatic logic cond_pass(input logic [2:0] cc, input flags_t f);
        logic ok;
        case (cc)
            CC_EQ:   ok = f.z;
            CC_NE:   ok = ~f.z;
            CC_GE:   ok = (f.n == f.v);
            CC_LT:   ok = (f.n != f.v);
            CC_AL:   ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input flags_t f);
        logic [STATUS_W-1:0] s;
        s        = '0;
        s[N_POS] = f.n;
        s[Z_POS] = f.z;
        s[C_POS] = f.c;
        s[V_POS] = f.v;
        return s;
    endfunction

endpackage

// File: rtl/flagalu_addsub.sv
module flagalu_addsub
    import flagalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output flags_t           fl
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;
    logic             cout;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[MSB:0];
        cout  = wide[WIDTH];
        fl.n  = sum[MSB];
        fl.z  = (sum == '0);
        // carry out on add, borrow (inverted carry) on subtract
        fl.c  = sub ? ~cout : cout;
        // same-sign inputs to the adder producing the opposite sign
        fl.v  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/flagalu_flagreg.sv
module flagalu_flagreg
    import flagalu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd,
    input  flags_t nxt,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (upd)
            q <= nxt;
    end
endmodule

// File: rtl/flagalu_condeval.sv
module flagalu_condeval
    import flagalu_pkg::*;
(
    input  logic [2:0] cc,
    input  flags_t     fl,
    output logic       pass
);
    always_comb pass = cond_pass(cc, fl);
endmodule

// File: rtl/flagalu_top.sv
module flagalu_top
    import flagalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          op,
    input  logic [2:0]          cond,
    input  logic [WIDTH-1:0]    opa,
    input  logic [WIDTH-1:0]    opb,
    output logic [WIDTH-1:0]    result,
    output logic                wr_en,
    output logic [STATUS_W-1:0] status
);
    logic [WIDTH-1:0] core_sum;
    flags_t           core_fl;
    flags_t           fl_q;
    logic             is_sub;
    logic             is_arith;
    logic             cc_ok;

    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_CMP);
        is_arith = (op != OP_MOV);
    end

    flagalu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (opa),
        .b   (opb),
        .sub (is_sub),
        .sum (core_sum),
        .fl  (core_fl)
    );

    flagalu_flagreg u_flags (
        .clk (clk),
        .rst (rst),
        .upd (in_valid && is_arith),
        .nxt (core_fl),
        .q   (fl_q)
    );

    flagalu_condeval u_cond (
        .cc   (cond),
        .fl   (fl_q),
        .pass (cc_ok)
    );

    always_comb begin
        result = (op == OP_MOV) ? opb : core_sum;
        wr_en  = in_valid && ((op == OP_ADD) || (op == OP_SUB) ||
                              ((op == OP_MOV) && cc_ok));
        status = pack_status(fl_q);
    end
endmodule

// File: rtl/flagalu_checker.sv
module flagalu_checker
    import flagalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [1:0]          op,
    input logic [WIDTH-1:0]    opa,
    input logic [WIDTH-1:0]    opb,
    input logic [WIDTH-1:0]    result,
    input logic                wr_en,
    input logic [STATUS_W-1:0] status
);
    localparam int MSB = WIDTH - 1;

    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CMP) |-> !wr_en);

    a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !wr_en);

    a_r9_mov_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MOV) |=> $stable(status));

    a_r9_idle_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(status));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        status[27:0] == '0);

    a_r3_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != OP_MOV) |=> (status[Z_POS] == ($past(result) == '0)));

    a_r5_mixed_sign_no_v: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_ADD && opa[MSB] != opb[MSB]) |=> !status[V_POS]);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (status == '0));
endmodule

bind flagalu_top flagalu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .result   (result),
    .wr_en    (wr_en),
    .status   (status)
);

// File: tb/test_flagalu_top.sv
`timescale 1ns/1ps
module test_flagalu_top;
    localparam int W  = 8;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   op;
    logic [2:0]   cond;
    logic [W-1:0] opa, opb;
    logic [W-1:0] result;
    logic         wr_en;
    logic [31:0]  status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flagalu_top #(.WIDTH(W)) i_flagalu_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cond(cond),
        .opa(opa), .opb(opb), .result(result), .wr_en(wr_en), .status(status)
    );

    // {op, cond, a, b, expected result, expected wr_en, expected {N,Z,C,V}}
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 3'd0, 8'd220, 8'd50,  8'd14,  1'b1, 4'b0010}, // R1 carry out
        {2'd0, 3'd0, 8'd100, 8'd50,  8'h96,  1'b1, 4'b1001}, // R5 pos+pos
        {2'd0, 3'd0, 8'h80,  8'h80,  8'h00,  1'b1, 4'b0111}, // R5 neg+neg
        {2'd0, 3'd0, 8'd127, 8'd127, 8'hFE,  1'b1, 4'b1001}, // R5 max+max
        {2'd1, 3'd0, 8'd10,  8'd3,   8'd7,   1'b1, 4'b0000}, // R2 no borrow
        {2'd1, 3'd0, 8'd3,   8'd10,  8'hF9,  1'b1, 4'b1010}, // R2 borrow
        {2'd2, 3'd0, 8'd5,   8'd5,   8'h00,  1'b0, 4'b0100}, // R7 equal
        {2'd3, 3'd0, 8'd0,   8'h33,  8'h33,  1'b1, 4'b0100}, // R8 EQ true
        {2'd3, 3'd1, 8'd0,   8'h44,  8'h44,  1'b0, 4'b0100}, // R8 NE false
        {2'd2, 3'd0, 8'h80,  8'h01,  8'h7F,  1'b0, 4'b0001}, // R6 V on sub
        {2'd3, 3'd2, 8'd0,   8'h11,  8'h11,  1'b0, 4'b0001}, // R8 GE false
        {2'd3, 3'd3, 8'd0,   8'h22,  8'h22,  1'b1, 4'b0001}, // R8 LT true
        {2'd3, 3'd4, 8'd0,   8'h55,  8'h55,  1'b1, 4'b0001}, // R8 AL
        {2'd0, 3'd0, 8'h7F,  8'h81,  8'h00,  1'b1, 4'b0110}, // R3 mixed sign zero
        {2'd3, 3'd5, 8'd0,   8'h66,  8'h66,  1'b0, 4'b0110}, // R8 reserved code
        {2'd2, 3'd0, 8'd3,   8'd10,  8'hF9,  1'b0, 4'b1010}, // R4 negative
        {2'd3, 3'd2, 8'd0,   8'h77,  8'h77,  1'b0, 4'b1010}, // R8 GE false (N!=V)
        {2'd3, 3'd3, 8'd0,   8'h88,  8'h88,  1'b1, 4'b1010}  // R8 LT true
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; cond = '0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 reset status", status, 32'h0);
        check("R9 idle wr_en", {31'b0, wr_en}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op = VEC[i][33:32]; cond = VEC[i][31:29];
            opa = VEC[i][28:21]; opb = VEC[i][20:13]; in_valid = 1'b1;
            #1;
            check("R1/R2/R8 result", {24'b0, result}, {24'b0, VEC[i][12:5]});
            check("R7/R8 wr_en", {31'b0, wr_en}, {31'b0, VEC[i][4]});
            @(posedge clk);
            #1;
            check("R3/R4/R5/R6 flags", {28'b0, status[31:28]}, {28'b0, VEC[i][3:0]});
            check("R10 reserved bits", {4'b0, status[27:0]}, 32'h0);
        end

        // R9: idle strobe with an add on the bus must neither write nor update
        @(negedge clk);
        in_valid = 1'b0; op = 2'd0; opa = 8'd1; opb = 8'd1;
        #1;
        check("R9 idle wr_en", {31'b0, wr_en}, 32'h0);
        @(posedge clk);
        #1;
        check("R9 idle flags hold", status, 32'hA000_0000);

        // R10: full status word layout after a flag set with all four bits varied
        @(negedge clk);
        in_valid = 1'b1; op = 2'd0; opa = 8'h80; opb = 8'h80;
        @(posedge clk);
        #1;
        check("R10 status word", status, 32'h7000_0000);

        // R11: synchronous reset mid-run clears flags even with a valid add present
        @(negedge clk);
        rst = 1'b1; op = 2'd0; opa = 8'd200; opb = 8'd100;
        @(posedge clk);
        #1;
        check("R11 sync reset", status, 32'h0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R11 stays clear", status, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule